// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Engine

This block is a single DMA channel. Software places a chain of four-word descriptors in memory, gives the channel the address of the first descriptor, and then rings a doorbell. For each descriptor, the channel fetches four words: command, source, target and count. It checks the source and target addresses against the block size. It then moves the data as a series of blocks. Each block is one read request at the source followed by one write request at the target. The block data itself is held in the memory system's staging buffer between the two requests.

After a block, the source and target addresses step forward only if their increment bits are set. When a descriptor has its link bit set, the channel fetches the next descriptor. The next address is the chain base plus sixteen times the byte in bits 31:24 of the count word. An offset of zero goes back to the chain base, so a ring of linked descriptors runs until software stops it. A descriptor with its link bit clear ends the chain. The channel then sets its termination flag and raises its interrupt if that descriptor asked for one.

Requests leave the block on one valid/ready channel. While `req_valid` is high and `req_ready` is low, the operation, address, byte count and width stay frozen. The channel never withdraws a request. At most one descriptor read is outstanding, and the memory returns exactly one `rsp_valid` beat for each accepted descriptor read, in any later cycle. The channel always accepts that beat, so there is no response back-pressure. Block requests get no response beat.

Top module: `dma_chain_engine`

## Requirements
- R1: Descriptor fetch.
  - A descriptor is fetched as four 4-byte reads (`req_op` 0, `req_bytes` 4, `req_width` 0).
  - The reads go to consecutive word addresses, starting at the descriptor address.
  - The words are taken in the order command, source, target, count.
- R2: Block transfers.
  - Count bits 23:0 give the number of blocks.
  - Each block is one read (`req_op` 1) at the source, then one write (`req_op` 2) at the target.
  - Command bits 10:8 set the block size in bytes: code 0 is 4, 1 is 1, 2 is 2, 3 is 16, 4 is 32, 5 is 64 and 6 is 128.
  - `req_width` carries command bits 15:14 on reads and bits 13:12 on writes.
  - A count of zero moves no blocks and completes the descriptor at once.
- R3: Address increment. Command bit 23 makes the source advance by the block size after each block, and bit 22 does the same for the target. With the bit clear, the address stays fixed.
- R4: Link.
  - With command bit 0 set, the next descriptor is fetched at chain base + 16 × count bits 31:24.
  - An offset of zero returns to the chain base, which makes the ring cyclic.
- R5: Chain end and interrupt.
  - When a descriptor with bit 0 clear completes, status bit 3 (termination) is set.
  - `irq` rises only if that descriptor had command bit 1 set.
  - `irq` stays low throughout any linked descriptor.
- R6: Address error.
  - These conditions each set status bit 4 (address error) and bit 2 (halt), and clear bit 0 (enable):
    - a source address not aligned to the block size;
    - a target address not aligned to the block size;
    - size code 7.
  - No block request is issued for that descriptor.
- R7: Status write.
  - A status write loads bit 0 into enable.
  - It clears the halt, termination and address-error flags and `irq`.
  - Writing 0 stops the channel at the next block boundary: a read already issued is followed by its write, and no further read is issued.
- R8: Descriptor format. A status write with bit 30 set leaves enable clear and sets the halt flag, because only the four-word descriptor format exists.
- R9: Doorbell.
  - A doorbell starts a chain at `chain_base` only if all of the following hold:
    - the channel is idle;
    - enable is set;
    - halt and address error are clear.
  - Otherwise no request follows.
- R10: Remaining count. `remain` shows the blocks left in the current descriptor. It equals the count field when the first block read is issued and is 0 after the descriptor ends.
- R11: Request holding. A request that is not yet accepted keeps `req_valid` high and its fields unchanged.
- R12: Reset. After reset, status, `irq`, `remain` and `req_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chain_base | input | 32 | Address of the first descriptor, sampled on the doorbell |
| doorbell | input | 1 | One-cycle start pulse |
| stat_wr | input | 1 | Status register write strobe |
| stat_wdata | input | 32 | Status write data (bit 0 enable, bit 30 format) |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory request accepted |
| req_op | output | 2 | 0 descriptor read, 1 block read, 2 block write |
| req_addr | output | 32 | Request byte address |
| req_bytes | output | 8 | Request length in bytes |
| req_width | output | 2 | Port width code (0 32-bit, 1 8-bit, 2 16-bit) |
| rsp_valid | input | 1 | Descriptor word returned |
| rsp_data | input | 32 | Descriptor word |
| status | output | 32 | Bit 0 enable, 2 halt, 3 termination, 4 address error |
| remain | output | 24 | Blocks left in the current descriptor |
| irq | output | 1 | Chain-end interrupt request |

## Verification
Several corner cases are driven on purpose:
- Linked descriptors are placed out of address order. A design that added the offset to the current descriptor, or that fetched descriptors sequentially, would read the wrong sources.
- A two-descriptor ring is left running past its wrap. The bench checks for a fetch back at the base and for no interrupt, which catches a design that treats offset zero as the end of the chain.
- The ring is stopped with a status write of 0. The bench then checks that every block read already issued has its write, and that no traffic follows.
- Unaligned sources, unaligned targets and the unused size code must all halt the channel before any block request.
- Zero-count descriptors, fixed addresses and bit-30 writes are also covered.

// File: rtl/dce_pkg.sv
package dce_pkg;

  localparam int WORD_W = 32;
  localparam int CNT_W  = 24;
  localparam int OFS_W  = 8;
  localparam int ALGN_W = 7;

  typedef enum logic [1:0] {
    OP_DESC = 2'd0,
    OP_BRD  = 2'd1,
    OP_BWR  = 2'd2
  } mem_op_e;

  localparam int ST_EN   = 0;
  localparam int ST_HALT = 2;
  localparam int ST_TERM = 3;
  localparam int ST_AERR = 4;
  localparam int ST_WIDE = 30;

  function automatic logic [7:0] size_to_bytes(input logic [2:0] code);
    case (code)
      3'd0:    size_to_bytes = 8'd4;
      3'd1:    size_to_bytes = 8'd1;
      3'd2:    size_to_bytes = 8'd2;
      3'd3:    size_to_bytes = 8'd16;
      3'd4:    size_to_bytes = 8'd32;
      3'd5:    size_to_bytes = 8'd64;
      3'd6:    size_to_bytes = 8'd128;
      default: size_to_bytes = 8'd0;
    endcase
  endfunction

endpackage

// File: rtl/dce_decode.sv
module dce_decode
  import dce_pkg::*;
(
  input  logic [WORD_W-1:0] cmd,
  input  logic [ALGN_W-1:0] src_lo,
  input  logic [ALGN_W-1:0] dst_lo,
  output logic [7:0]        blk_bytes,
  output logic              bad,
  output logic              link,
  output logic              tie,
  output logic              sinc,
  output logic              dinc,
  output logic [1:0]        src_w,
  output logic [1:0]        dst_w
);

  logic [7:0] mask;
  logic       unused_cmd;

  always_comb begin
    blk_bytes = size_to_bytes(cmd[10:8]);
    mask      = blk_bytes - 8'd1;
    // R6: unused size code or an address off the block grid is an error
    bad = (blk_bytes == 8'd0) ||
          (|({1'b0, src_lo} & mask)) ||
          (|({1'b0, dst_lo} & mask));
    link  = cmd[0];
    tie   = cmd[1];
    dinc  = cmd[22];
    sinc  = cmd[23];
    dst_w = cmd[13:12];
    src_w = cmd[15:14];
  end

  assign unused_cmd = ^{cmd[31:24], cmd[21:16], cmd[11], cmd[7:2]};

endmodule

// File: rtl/dce_status.sv
module dce_status
  import dce_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              ev_term,
  input  logic              ev_tie,
  input  logic              ev_aerr,
  output logic [WORD_W-1:0] status,
  output logic              irq
);

  logic en_q, halt_q, term_q, aerr_q, irq_q;
  logic unused_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      halt_q <= 1'b0;
      term_q <= 1'b0;
      aerr_q <= 1'b0;
      irq_q  <= 1'b0;
    end else if (wr_en) begin
      // R7 and R8: a write reloads enable and clears every flag
      en_q   <= wr_data[ST_EN] & ~wr_data[ST_WIDE];
      halt_q <= wr_data[ST_WIDE];
      term_q <= 1'b0;
      aerr_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (ev_aerr) begin
        aerr_q <= 1'b1;
        halt_q <= 1'b1;
        en_q   <= 1'b0;
      end
      if (ev_term) begin
        term_q <= 1'b1;
        if (ev_tie) irq_q <= 1'b1;
      end
    end
  end

  always_comb begin
    status          = '0;
    status[ST_EN]   = en_q;
    status[ST_HALT] = halt_q;
    status[ST_TERM] = term_q;
    status[ST_AERR] = aerr_q;
  end
  assign irq = irq_q;

  assign unused_wdata = ^{wr_data[31], wr_data[29:1]};

  a_r5_irq_needs_term: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> term_q);
  a_r6_aerr_with_halt: assert property (@(posedge clk) disable iff (!rst_n)
    aerr_q |-> (halt_q && !en_q));

endmodule

// File: rtl/dce_sequencer.sv
module dce_sequencer
  import dce_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              doorbell,
  input  logic [AW-1:0]     chain_base,
  input  logic              ch_en,
  input  logic              ch_blocked,
  input  logic              req_ready,
  input  logic              rsp_valid,
  input  logic [WORD_W-1:0] rsp_data,
  input  logic [7:0]        blk_bytes,
  input  logic              bad,
  input  logic              link,
  input  logic              tie,
  input  logic              sinc,
  input  logic              dinc,
  input  logic [1:0]        src_w,
  input  logic [1:0]        dst_w,
  output logic              req_valid,
  output mem_op_e           req_op,
  output logic [AW-1:0]     req_addr,
  output logic [7:0]        req_bytes,
  output logic [1:0]        req_width,
  output logic [WORD_W-1:0] cmd_q,
  output logic [AW-1:0]     src_q,
  output logic [AW-1:0]     dst_q,
  output logic [CNT_W-1:0]  remain,
  output logic              ev_term,
  output logic              ev_tie,
  output logic              ev_aerr
);

  localparam int PAD_OFS = AW - OFS_W - 4;
  localparam int PAD_WRD = AW - 4;

  typedef enum logic [2:0] {
    S_IDLE, S_FREQ, S_FWAIT, S_CHECK, S_RD, S_WR, S_END
  } seq_state_e;

  seq_state_e          st;
  logic [AW-1:0]       base_q, ptr_q;
  logic [1:0]          widx;
  logic [CNT_W-1:0]    cnt_q;
  logic [OFS_W-1:0]    ofs_q;
  logic [AW-1:0]       step;
  logic                hs;

  assign hs   = req_valid && req_ready;
  assign step = {{(AW-8){1'b0}}, blk_bytes};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      base_q <= '0;
      ptr_q  <= '0;
      widx   <= '0;
      cnt_q  <= '0;
      ofs_q  <= '0;
      cmd_q  <= '0;
      src_q  <= '0;
      dst_q  <= '0;
    end else begin
      case (st)
        S_IDLE: if (doorbell && ch_en && !ch_blocked) begin
          base_q <= chain_base;
          ptr_q  <= chain_base;
          widx   <= '0;
          st     <= S_FREQ;
        end
        S_FREQ: if (hs) st <= S_FWAIT;
        S_FWAIT: if (rsp_valid) begin
          case (widx)
            2'd0: cmd_q <= rsp_data;
            2'd1: src_q <= rsp_data[AW-1:0];
            2'd2: dst_q <= rsp_data[AW-1:0];
            default: begin
              cnt_q <= rsp_data[CNT_W-1:0];
              ofs_q <= rsp_data[WORD_W-1:CNT_W];
            end
          endcase
          widx <= widx + 2'd1;
          st   <= (widx == 2'd3) ? S_CHECK : S_FREQ;
        end
        S_CHECK: begin
          if (bad || !ch_en)        st <= S_IDLE;
          else if (cnt_q == '0)     st <= S_END;
          else                      st <= S_RD;
        end
        S_RD: if (hs) st <= S_WR;
        S_WR: if (hs) begin
          cnt_q <= cnt_q - 1'b1;
          if (sinc) src_q <= src_q + step;
          if (dinc) dst_q <= dst_q + step;
          if (cnt_q == 1)   st <= S_END;
          else if (!ch_en)  st <= S_IDLE;
          else              st <= S_RD;
        end
        S_END: begin
          if (link && ch_en) begin
            ptr_q <= base_q + {{PAD_OFS{1'b0}}, ofs_q, 4'b0000};
            widx  <= '0;
            st    <= S_FREQ;
          end else begin
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    req_valid = 1'b0;
    req_op    = OP_DESC;
    req_addr  = ptr_q + {{PAD_WRD{1'b0}}, widx, 2'b00};
    req_bytes = 8'd4;
    req_width = 2'd0;
    case (st)
      S_FREQ: req_valid = 1'b1;
      S_RD: begin
        req_valid = 1'b1;
        req_op    = OP_BRD;
        req_addr  = src_q;
        req_bytes = blk_bytes;
        req_width = src_w;
      end
      S_WR: begin
        req_valid = 1'b1;
        req_op    = OP_BWR;
        req_addr  = dst_q;
        req_bytes = blk_bytes;
        req_width = dst_w;
      end
      default: ;
    endcase
  end

  assign remain  = cnt_q;
  assign ev_term = (st == S_END) && !link;
  assign ev_tie  = ev_term && tie;
  assign ev_aerr = (st == S_CHECK) && bad;

  a_r10_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && req_op == OP_BWR) |=> (remain == $past(remain) - 1'b1));
  a_r1_desc_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_DESC) |-> (req_addr[1:0] == 2'b00 && req_bytes == 8'd4));
  a_r2_block_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op != OP_DESC) |-> (req_bytes != 8'd0));

endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine
  import dce_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     chain_base,
  input  logic              doorbell,
  input  logic              stat_wr,
  input  logic [WORD_W-1:0] stat_wdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [1:0]        req_op,
  output logic [AW-1:0]     req_addr,
  output logic [7:0]        req_bytes,
  output logic [1:0]        req_width,
  input  logic              rsp_valid,
  input  logic [WORD_W-1:0] rsp_data,
  output logic [WORD_W-1:0] status,
  output logic [CNT_W-1:0]  remain,
  output logic              irq
);

  logic [WORD_W-1:0] cmd_q;
  logic [AW-1:0]     src_q, dst_q;
  logic [7:0]        blk_bytes;
  logic              bad, link, tie, sinc, dinc;
  logic [1:0]        src_w, dst_w;
  logic              ev_term, ev_tie, ev_aerr;
  mem_op_e           op_e;

  dce_decode u_dec (
    .cmd(cmd_q), .src_lo(src_q[ALGN_W-1:0]), .dst_lo(dst_q[ALGN_W-1:0]),
    .blk_bytes(blk_bytes), .bad(bad), .link(link), .tie(tie),
    .sinc(sinc), .dinc(dinc), .src_w(src_w), .dst_w(dst_w)
  );

  dce_status u_stat (
    .clk(clk), .rst_n(rst_n), .wr_en(stat_wr), .wr_data(stat_wdata),
    .ev_term(ev_term), .ev_tie(ev_tie), .ev_aerr(ev_aerr),
    .status(status), .irq(irq)
  );

  dce_sequencer #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .doorbell(doorbell), .chain_base(chain_base),
    .ch_en(status[ST_EN]), .ch_blocked(status[ST_HALT] | status[ST_AERR]),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .blk_bytes(blk_bytes), .bad(bad), .link(link), .tie(tie),
    .sinc(sinc), .dinc(dinc), .src_w(src_w), .dst_w(dst_w),
    .req_valid(req_valid), .req_op(op_e), .req_addr(req_addr),
    .req_bytes(req_bytes), .req_width(req_width),
    .cmd_q(cmd_q), .src_q(src_q), .dst_q(dst_q), .remain(remain),
    .ev_term(ev_term), .ev_tie(ev_tie), .ev_aerr(ev_aerr)
  );

  assign req_op = op_e;

  a_r11_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_op) &&
      $stable(req_addr) && $stable(req_bytes) && $stable(req_width)));
  a_r6_no_request_on_error: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[ST_AERR]) |-> !req_valid);

endmodule

// File: tb/tb_dma_chain_engine.sv
module tb_dma_chain_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] chain_base = '0;
  logic        doorbell = 1'b0;
  logic        stat_wr = 1'b0;
  logic [31:0] stat_wdata = '0;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic [1:0]  req_op;
  logic [31:0] req_addr;
  logic [7:0]  req_bytes;
  logic [1:0]  req_width;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_data = '0;
  logic [31:0] status;
  logic [23:0] remain;
  logic        irq;

  always #4 clk = ~clk;

  dma_chain_engine dut (
    .clk(clk), .rst_n(rst_n), .chain_base(chain_base), .doorbell(doorbell),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_op(req_op), .req_addr(req_addr),
    .req_bytes(req_bytes), .req_width(req_width), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .status(status), .remain(remain), .irq(irq)
  );

  int errors = 0;
  int checks = 0;

  logic [31:0] mem [0:255];
  logic [31:0] rd_addr [0:255];
  logic [7:0]  rd_bytes [0:255];
  logic [1:0]  rd_width [0:255];
  logic [23:0] rd_rem [0:255];
  logic        rd_irq [0:255];
  logic [31:0] wr_addr [0:255];
  logic [1:0]  wr_width [0:255];
  logic [31:0] ds_addr [0:255];
  int n_rd = 0, n_wr = 0, n_ds = 0;
  int cyc = 0;
  logic        pend = 1'b0;
  logic [31:0] pend_addr = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // memory model and traffic monitor, all on the falling edge
  always @(negedge clk) begin
    cyc++;
    rsp_valid = 1'b0;
    if (pend) begin
      rsp_valid = 1'b1;
      rsp_data  = mem[pend_addr[9:2]];
      pend      = 1'b0;
    end
    req_ready = (cyc % 3) != 0;
    if (rst_n && req_valid && req_ready) begin
      case (req_op)
        2'd0: begin
          if (n_ds < 256) ds_addr[n_ds] = req_addr;
          n_ds++;
          pend = 1'b1;
          pend_addr = req_addr;
        end
        2'd1: begin
          if (n_rd < 256) begin
            rd_addr[n_rd] = req_addr;  rd_bytes[n_rd] = req_bytes;
            rd_width[n_rd] = req_width; rd_rem[n_rd] = remain; rd_irq[n_rd] = irq;
          end
          n_rd++;
        end
        default: begin
          if (n_wr < 256) begin
            wr_addr[n_wr] = req_addr; wr_width[n_wr] = req_width;
          end
          n_wr++;
        end
      endcase
    end
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr_status(input logic [31:0] v);
    @(negedge clk); stat_wr = 1'b1; stat_wdata = v;
    @(negedge clk); stat_wr = 1'b0;
  endtask

  task automatic ring(input logic [31:0] base);
    @(negedge clk); doorbell = 1'b1; chain_base = base;
    @(negedge clk); doorbell = 1'b0;
  endtask

  task automatic wait_done();
    for (int t = 0; t < 3000; t++) begin
      @(negedge clk);
      if (status[3] || status[4] || status[2]) break;
    end
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [7:0] bytes_of(input logic [2:0] c);
    case (c)
      3'd0: return 8'd4;   3'd1: return 8'd1;  3'd2: return 8'd2;
      3'd3: return 8'd16;  3'd4: return 8'd32; 3'd5: return 8'd64;
      3'd6: return 8'd128; default: return 8'd0;
    endcase
  endfunction

  typedef struct packed {
    logic [31:0] cmd;
    logic [31:0] src;
    logic [31:0] dst;
    logic [23:0] cnt;
    logic [7:0]  nblk;
    logic        aerr;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{cmd:32'h00C06002, src:32'h1000, dst:32'h2000, cnt:24'd3, nblk:8'd3, aerr:1'b0},
    '{cmd:32'h00800100, src:32'h1003, dst:32'h3001, cnt:24'd5, nblk:8'd5, aerr:1'b0},
    '{cmd:32'h00400302, src:32'h4000, dst:32'h5010, cnt:24'd2, nblk:8'd2, aerr:1'b0},
    '{cmd:32'h00C00602, src:32'h8000, dst:32'h8080, cnt:24'd1, nblk:8'd1, aerr:1'b0},
    '{cmd:32'h00800202, src:32'h1001, dst:32'h2000, cnt:24'd4, nblk:8'd0, aerr:1'b1},
    '{cmd:32'h00400400, src:32'h2000, dst:32'h2010, cnt:24'd2, nblk:8'd0, aerr:1'b1},
    '{cmd:32'h00000700, src:32'h0000, dst:32'h0000, cnt:24'd1, nblk:8'd0, aerr:1'b1},
    '{cmd:32'h00000502, src:32'h0040, dst:32'h0080, cnt:24'd0, nblk:8'd0, aerr:1'b0}
  };

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(status == 32'h0, "R12 status", status, 32'h0);
    chk(irq == 1'b0, "R12 irq", {31'b0, irq}, 32'h0);
    chk(req_valid == 1'b0, "R12 req_valid", {31'b0, req_valid}, 32'h0);
    chk(remain == 24'h0, "R12 remain", {8'b0, remain}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R9 doorbell while disabled
    ring(32'h0);
    repeat (20) @(negedge clk);
    chk(n_ds == 0, "R9 disabled doorbell", n_ds, 0);

    // R8 eight-word format request
    wr_status(32'h4000_0001);
    chk(status == 32'h4, "R8 bit30 write", status, 32'h4);
    ring(32'h0);
    repeat (20) @(negedge clk);
    chk(n_ds == 0, "R9 halted doorbell", n_ds, 0);

    // table of single descriptors
    for (int v = 0; v < NV; v++) begin
      automatic vec_t e = VEC[v];
      automatic int rb = n_rd, wb = n_wr, db = n_ds;
      automatic logic [7:0] by = bytes_of(e.cmd[10:8]);
      automatic logic [31:0] lsrc = e.src + (e.cmd[23] ? (e.cnt - 1) * by : 0);
      automatic logic [31:0] ldst = e.dst + (e.cmd[22] ? (e.cnt - 1) * by : 0);
      automatic logic [31:0] est;
      mem[0] = e.cmd; mem[1] = e.src; mem[2] = e.dst; mem[3] = {8'h00, e.cnt};
      wr_status(32'h1);
      chk(status == 32'h1, "R7 write clears flags", status, 32'h1);
      ring(32'h0);
      wait_done();
      chk(n_ds - db == 4, "R1 four descriptor reads", n_ds - db, 4);
      chk(ds_addr[db+3] == 32'hC, "R1 count word address", ds_addr[db+3], 32'hC);
      chk(n_rd - rb == int'(e.nblk), "R2 block reads", n_rd - rb, e.nblk);
      chk(n_wr - wb == int'(e.nblk), "R2 block writes", n_wr - wb, e.nblk);
      if (e.nblk != 0) begin
        chk(rd_addr[rb] == e.src, "R2 first source", rd_addr[rb], e.src);
        chk(rd_bytes[rb] == by, "R2 block bytes", rd_bytes[rb], by);
        chk(rd_width[rb] == e.cmd[15:14], "R2 read width", rd_width[rb], e.cmd[15:14]);
        chk(wr_width[wb] == e.cmd[13:12], "R2 write width", wr_width[wb], e.cmd[13:12]);
        chk(rd_rem[rb] == e.cnt, "R10 remain at first read", rd_rem[rb], e.cnt);
        chk(rd_addr[n_rd-1] == lsrc, "R3 last source", rd_addr[n_rd-1], lsrc);
        chk(wr_addr[n_wr-1] == ldst, "R3 last target", wr_addr[n_wr-1], ldst);
      end
      est = e.aerr ? 32'h14 : 32'h9;
      chk(status == est, e.aerr ? "R6 error status" : "R5 end status", status, est);
      chk(irq == (e.cmd[1] && !e.aerr), "R5 irq", irq, e.cmd[1] && !e.aerr);
      if (!e.aerr) chk(remain == 0, "R10 remain at end", remain, 0);
    end

    // R4 chain placed out of address order, base 0x100
    mem[64] = 32'h00800001; mem[65] = 32'h1000; mem[66] = 32'h2000; mem[67] = 32'h02000001;
    mem[72] = 32'h00800001; mem[73] = 32'h1100; mem[74] = 32'h2000; mem[75] = 32'h01000001;
    mem[68] = 32'h00800002; mem[69] = 32'h1200; mem[70] = 32'h2000; mem[71] = 32'h00000001;
    begin
      automatic int rb = n_rd;
      wr_status(32'h1);
      ring(32'h100);
      wait_done();
      chk(n_rd - rb == 3, "R4 chain blocks", n_rd - rb, 3);
      chk(rd_addr[rb]   == 32'h1000, "R4 chain first", rd_addr[rb], 32'h1000);
      chk(rd_addr[rb+1] == 32'h1100, "R4 chain second", rd_addr[rb+1], 32'h1100);
      chk(rd_addr[rb+2] == 32'h1200, "R4 chain third", rd_addr[rb+2], 32'h1200);
      chk(!rd_irq[rb+1] && !rd_irq[rb+2], "R5 no irq mid chain", {rd_irq[rb+1], rd_irq[rb+2]}, 0);
      chk(irq == 1'b1, "R5 irq at chain end", irq, 1);
    end

    // R4 cyclic ring at 0x200 then R7 stop
    mem[128] = 32'h00800001; mem[129] = 32'h3000; mem[130] = 32'h6000; mem[131] = 32'h01000002;
    mem[132] = 32'h00800001; mem[133] = 32'h3100; mem[134] = 32'h6000; mem[135] = 32'h00000001;
    begin
      automatic int rb = n_rd, db = n_ds, r1, w1;
      wr_status(32'h1);
      ring(32'h200);
      for (int t = 0; t < 3000; t++) begin
        @(negedge clk);
        if (n_rd - rb >= 8) break;
      end
      chk(rd_addr[rb+3] == 32'h3000, "R4 ring wraps", rd_addr[rb+3], 32'h3000);
      chk(rd_addr[rb+5] == 32'h3100, "R4 ring second pass", rd_addr[rb+5], 32'h3100);
      chk(ds_addr[db+8] == 32'h200, "R4 refetch at base", ds_addr[db+8], 32'h200);
      chk(irq == 1'b0 && status[3] == 1'b0, "R5 ring never ends", {status[3], irq}, 0);
      wr_status(32'h0);
      repeat (40) @(negedge clk);
      r1 = n_rd; w1 = n_wr;
      chk(r1 == w1, "R7 stop on block boundary", r1, w1);
      repeat (30) @(negedge clk);
      chk(n_rd == r1 && n_wr == w1, "R7 no traffic after stop", n_rd, r1);
      chk(status == 32'h0, "R7 stop status", status, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule